// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges every reset cause of a small microcontroller core into one internal reset and plays out a fixed release sequence. A power-on pulse starts a long hold in which the CPU and peripheral clocks stay gated so the oscillator can settle. After that come two equal hold windows and a two-cycle reset-vector fetch. A watchdog overflow, an illegal-opcode strobe (or a STOP instruction while STOP is disabled) or a low level on the external reset pin starts the same sequence from the first window, with no settle hold. The controller drives the open-drain reset pin low while the clocks are gated and through the first window, so the rest of the board sees every internal reset.

A four-bit cause register, which software can only read, records what started the most recent sequence. A combinational qualifier decides when the watchdog may be switched off. It allows this only when a high test voltage is detected on a pin in the right debug context.

Top module: `rstc_top`

## Requirements
- R1: While `por_pulse` is high, and until the SETTLE_CYCLES-th rising clock edge after it goes low, `clk_run` is 0 and both `int_rst` and `rst_pin_low` are 1. On that edge `clk_run` becomes 1.
- R2: After the settle hold, `rst_pin_low` stays 1 for WIN_CYCLES more rising edges and then drops to 0. `int_rst` stays 1 for a second run of WIN_CYCLES edges and then drops to 0.
- R3: When `int_rst` drops, `vec_valid` is 1 for two cycles. `vec_addr` is 0xFFFE in the first and 0xFFFF in the second. After that, `vec_valid` is 0 and `vec_addr` is 0.
- R4: Status bit 0 marks power-on, bit 1 the watchdog, bit 2 an illegal opcode and bit 3 the external pin. After power-on, `status` reads 4'b0001.
- R5: A `wdog_ovf` seen while running sets `int_rst` and `rst_pin_low` on that edge and sets `status` to 4'b0010. It runs the two windows without gating the clocks.
- R6: An `illop_stb` seen while running starts the same sequence as R5 and sets `status` to 4'b0100.
- R7: A `stop_stb` with `stop_en` = 0 acts exactly like `illop_stb`. With `stop_en` = 1 it has no effect on any output.
- R8: `pin_level` = 0 seen while running starts the sequence of R5 and sets `status` to 4'b1000. A low pin level while the controller itself is in reset is not a new request.
- R9: When several sources fire on one edge, only the highest one is recorded. The order is power-on, then watchdog, then illegal opcode, then pin.
- R10: A watchdog or illegal-opcode request during a sequence ORs its bit into `status`. In either window it restarts that window's count. In the vector fetch it returns to the start of the second window. During the settle hold it does not lengthen the hold.
- R11: While `int_rst` is 0, `status` keeps its value until the next reset request.
- R12: `wdog_disable` is 1 only when (`monitor_mode` and (`vtst_rst` or `vtst_irq`)) or (`break_state` and `vtst_rst`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| wdog_ovf | input | 1 | Watchdog counter overflow |
| illop_stb | input | 1 | Illegal-opcode strobe from the CPU |
| stop_stb | input | 1 | STOP instruction strobe from the CPU |
| stop_en | input | 1 | Configuration bit, 1 allows STOP |
| pin_level | input | 1 | Sensed level of the external reset pin |
| monitor_mode | input | 1 | Core is in monitor mode |
| break_state | input | 1 | Core is in a break state |
| vtst_rst | input | 1 | Test voltage detected on the reset pin |
| vtst_irq | input | 1 | Test voltage detected on the interrupt pin |
| int_rst | output | 1 | Internal reset to CPU and modules |
| clk_run | output | 1 | Enable for the CPU and module clocks |
| rst_pin_low | output | 1 | Pull the reset pin low (open-drain drive) |
| status | output | 4 | Reset cause register, read-only |
| vec_valid | output | 1 | Reset-vector fetch in progress |
| vec_addr | output | 16 | Reset-vector byte address |
| wdog_disable | output | 1 | Watchdog may be disabled |

## Verification
The sequence is started by a clean power-on, by a power-on with a watchdog strobe inside the settle hold, and by each single source from the running state. These runs tell apart the full settle path, the window-only path and the per-source status encoding. Coincident requests (all three, illegal plus pin, disabled STOP plus pin) separate the priority order from a plain OR. Requests injected inside the first window and inside the vector fetch show whether the window restart and the fall-back to the second window are correct. The pin is looped back through the controller's own drive, so the bench can tell a real external request apart from the controller's echo.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

   typedef enum logic [2:0] {
      PH_RUN    = 3'd0,
      PH_SETTLE = 3'd1,
      PH_HOLD   = 3'd2,
      PH_REL    = 3'd3,
      PH_VLO    = 3'd4,
      PH_VHI    = 3'd5
   } phase_t;

   localparam int NSRC     = 4;
   localparam int SRC_POR  = 0;
   localparam int SRC_WDOG = 1;
   localparam int SRC_ILL  = 2;
   localparam int SRC_PIN  = 3;

endpackage

// File: rtl/rstc_src_arb.sv
module rstc_src_arb
   import rstc_pkg::*;
(
   input  logic            por_pulse,
   input  logic            wdog_ovf,
   input  logic            illop_stb,
   input  logic            stop_stb,
   input  logic            stop_en,
   input  logic            pin_req,
   output logic [NSRC-1:0] pick
);

   logic [NSRC-1:0] raw;

   always_comb begin
      raw           = '0;
      raw[SRC_POR]  = por_pulse;
      raw[SRC_WDOG] = wdog_ovf;
      raw[SRC_ILL]  = illop_stb | (stop_stb & ~stop_en);
      raw[SRC_PIN]  = pin_req;
   end

   // lower index wins
   for (genvar i = 0; i < NSRC; i++) begin : g_pri
      if (i == 0) begin : g_first
         assign pick[i] = raw[i];
      end else begin : g_rest
         assign pick[i] = raw[i] & ~(|raw[i-1:0]);
      end
   end

endmodule

// File: rtl/rstc_wdog_qual.sv
module rstc_wdog_qual (
   input  logic monitor_mode,
   input  logic break_state,
   input  logic vtst_rst,
   input  logic vtst_irq,
   output logic wdog_disable
);

   logic hv_any;
   logic mon_ok;
   logic brk_ok;

   always_comb begin
      hv_any       = vtst_rst | vtst_irq;
      mon_ok       = monitor_mode & hv_any;
      brk_ok       = break_state & vtst_rst;
      wdog_disable = mon_ok | brk_ok;
   end

endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
   import rstc_pkg::*;
#(
   parameter int SETTLE_CYCLES = 4096,
   parameter int WIN_CYCLES    = 32
) (
   input  logic            clk,
   input  logic            por_pulse,
   input  logic [NSRC-1:0] pick,
   output phase_t          phase,
   output logic [NSRC-1:0] status
);

   localparam int MAXC = (SETTLE_CYCLES > WIN_CYCLES) ? SETTLE_CYCLES : WIN_CYCLES;
   localparam int CW   = $clog2(MAXC);

   if (SETTLE_CYCLES < 2) begin : g_bad_settle
      $error("rstc_seq: SETTLE_CYCLES must be at least 2");
   end
   if (WIN_CYCLES < 2) begin : g_bad_win
      $error("rstc_seq: WIN_CYCLES must be at least 2");
   end

   logic [CW-1:0]   cnt, cnt_nx;
   phase_t          ph_nx;
   logic [NSRC-1:0] st_nx;
   logic            hit;
   logic            last;

   always_comb begin
      hit  = |pick[NSRC-1:1];
      last = (phase == PH_SETTLE) ? (cnt == CW'(SETTLE_CYCLES - 1))
                                  : (cnt == CW'(WIN_CYCLES - 1));
      ph_nx  = phase;
      cnt_nx = cnt + 1'b1;
      st_nx  = status;
      case (phase)
         PH_RUN: begin
            cnt_nx = '0;
            if (hit) begin
               ph_nx = PH_HOLD;
               st_nx = pick;
            end
         end
         PH_SETTLE: begin
            if (hit) st_nx = status | pick;
            if (last) begin
               ph_nx  = PH_HOLD;
               cnt_nx = '0;
            end
         end
         PH_HOLD, PH_REL: begin
            if (hit) begin
               st_nx  = status | pick;
               cnt_nx = '0;
            end else if (last) begin
               ph_nx  = (phase == PH_HOLD) ? PH_REL : PH_VLO;
               cnt_nx = '0;
            end
         end
         PH_VLO, PH_VHI: begin
            cnt_nx = '0;
            if (hit) begin
               st_nx = status | pick;
               ph_nx = PH_REL;
            end else begin
               ph_nx = (phase == PH_VLO) ? PH_VHI : PH_RUN;
            end
         end
         default: begin
            ph_nx  = PH_RUN;
            cnt_nx = '0;
         end
      endcase
   end

   always_ff @(posedge clk or posedge por_pulse) begin
      if (por_pulse) begin
         phase  <= PH_SETTLE;
         cnt    <= '0;
         status <= NSRC'(1) << SRC_POR;
      end else begin
         phase  <= ph_nx;
         cnt    <= cnt_nx;
         status <= st_nx;
      end
   end

endmodule

// File: rtl/rstc_top.sv
module rstc_top
   import rstc_pkg::*;
#(
   parameter int          SETTLE_CYCLES = 4096,
   parameter int          WIN_CYCLES    = 32,
   parameter int          VEC_W         = 16,
   parameter logic [15:0] VEC_BASE      = 16'hFFFE
) (
   input  logic             clk,
   input  logic             por_pulse,
   input  logic             wdog_ovf,
   input  logic             illop_stb,
   input  logic             stop_stb,
   input  logic             stop_en,
   input  logic             pin_level,
   input  logic             monitor_mode,
   input  logic             break_state,
   input  logic             vtst_rst,
   input  logic             vtst_irq,
   output logic             int_rst,
   output logic             clk_run,
   output logic             rst_pin_low,
   output logic [3:0]       status,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_addr,
   output logic             wdog_disable
);

   if (VEC_W != 16) begin : g_bad_w
      $error("rstc_top: VEC_W must be 16");
   end
   if (VEC_BASE[0] != 1'b0) begin : g_bad_base
      $error("rstc_top: VEC_BASE must be even");
   end
   if (NSRC != 4) begin : g_bad_src
      $error("rstc_top: status width mismatch");
   end

   phase_t          phase;
   logic [NSRC-1:0] pick;
   logic            running;
   logic            pin_req;

   assign running = (phase == PH_RUN);
   assign pin_req = ~pin_level & running;

   rstc_src_arb u_arb (
      .por_pulse (por_pulse),
      .wdog_ovf  (wdog_ovf),
      .illop_stb (illop_stb),
      .stop_stb  (stop_stb),
      .stop_en   (stop_en),
      .pin_req   (pin_req),
      .pick      (pick)
   );

   rstc_seq #(
      .SETTLE_CYCLES (SETTLE_CYCLES),
      .WIN_CYCLES    (WIN_CYCLES)
   ) u_seq (
      .clk       (clk),
      .por_pulse (por_pulse),
      .pick      (pick),
      .phase     (phase),
      .status    (status)
   );

   rstc_wdog_qual u_wq (
      .monitor_mode (monitor_mode),
      .break_state  (break_state),
      .vtst_rst     (vtst_rst),
      .vtst_irq     (vtst_irq),
      .wdog_disable (wdog_disable)
   );

   always_comb begin
      int_rst     = (phase == PH_SETTLE) | (phase == PH_HOLD) | (phase == PH_REL);
      clk_run     = (phase != PH_SETTLE);
      rst_pin_low = (phase == PH_SETTLE) | (phase == PH_HOLD);
      vec_valid   = (phase == PH_VLO) | (phase == PH_VHI);
      case (phase)
         PH_VLO:  vec_addr = VEC_BASE;
         PH_VHI:  vec_addr = VEC_BASE | 16'h0001;
         default: vec_addr = '0;
      endcase
   end

endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
   parameter logic [15:0] VEC_BASE = 16'hFFFE
) (
   input logic        clk,
   input logic        por_pulse,
   input logic        wdog_ovf,
   input logic        illop_stb,
   input logic        stop_stb,
   input logic        stop_en,
   input logic        monitor_mode,
   input logic        break_state,
   input logic        vtst_rst,
   input logic        vtst_irq,
   input logic        int_rst,
   input logic        clk_run,
   input logic        rst_pin_low,
   input logic [3:0]  status,
   input logic        vec_valid,
   input logic [15:0] vec_addr,
   input logic        wdog_disable
);

   logic quiet;
   assign quiet = !wdog_ovf && !illop_stb && !(stop_stb && !stop_en);

   // R1
   gated_hold_chk: assert property (@(posedge clk) disable iff (por_pulse)
      !clk_run |-> (int_rst && rst_pin_low));

   // R2
   pin_release_chk: assert property (@(posedge clk) disable iff (por_pulse)
      $fell(rst_pin_low) |-> (int_rst && clk_run));

   // R3
   vec_order_chk: assert property (@(posedge clk) disable iff (por_pulse)
      (vec_valid && vec_addr == VEC_BASE && quiet) |=>
         (vec_valid && vec_addr == (VEC_BASE | 16'h0001)));

   // R3
   vec_after_rst_chk: assert property (@(posedge clk) disable iff (por_pulse)
      $rose(vec_valid) |-> $past(int_rst));

   // R4
   por_status_chk: assert property (@(posedge clk) disable iff (por_pulse)
      $fell(por_pulse) |-> (status == 4'b0001));

   // R5
   wdog_entry_chk: assert property (@(posedge clk) disable iff (por_pulse)
      (!int_rst && !vec_valid && wdog_ovf) |=>
         (int_rst && rst_pin_low && clk_run && status == 4'b0010));

   // R11
   status_hold_chk: assert property (@(posedge clk) disable iff (por_pulse)
      !int_rst |-> $stable(status));

   // R12
   wdog_mode_chk: assert property (@(posedge clk) disable iff (por_pulse)
      (!monitor_mode && !break_state) |-> !wdog_disable);

   // R12
   wdog_volt_chk: assert property (@(posedge clk) disable iff (por_pulse)
      (!vtst_rst && !vtst_irq) |-> !wdog_disable);

endmodule

bind rstc_top rstc_chk #(.VEC_BASE(VEC_BASE)) u_chk (
   .clk          (clk),
   .por_pulse    (por_pulse),
   .wdog_ovf     (wdog_ovf),
   .illop_stb    (illop_stb),
   .stop_stb     (stop_stb),
   .stop_en      (stop_en),
   .monitor_mode (monitor_mode),
   .break_state  (break_state),
   .vtst_rst     (vtst_rst),
   .vtst_irq     (vtst_irq),
   .int_rst      (int_rst),
   .clk_run      (clk_run),
   .rst_pin_low  (rst_pin_low),
   .status       (status),
   .vec_valid    (vec_valid),
   .vec_addr     (vec_addr),
   .wdog_disable (wdog_disable)
);

// File: tb/tb_rstc_top.sv
`timescale 1ns/1ps
module tb_rstc_top;

   localparam int S = 4096;
   localparam int W = 32;

   logic clk = 1'b0;
   logic por_pulse = 1'b0;
   logic wdog_ovf = 1'b0, illop_stb = 1'b0, stop_stb = 1'b0, stop_en = 1'b1;
   logic ext_pin_low = 1'b0;
   logic pin_level;
   logic monitor_mode = 1'b0, break_state = 1'b0, vtst_rst = 1'b0, vtst_irq = 1'b0;
   logic int_rst, clk_run, rst_pin_low, vec_valid, wdog_disable;
   logic [3:0]  status;
   logic [15:0] vec_addr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   // wired-AND pin: external pull-down or the controller's own drive
   assign pin_level = ext_pin_low ? 1'b0 : !rst_pin_low;

   rstc_top dut (
      .clk(clk), .por_pulse(por_pulse), .wdog_ovf(wdog_ovf), .illop_stb(illop_stb),
      .stop_stb(stop_stb), .stop_en(stop_en), .pin_level(pin_level),
      .monitor_mode(monitor_mode), .break_state(break_state), .vtst_rst(vtst_rst),
      .vtst_irq(vtst_irq), .int_rst(int_rst), .clk_run(clk_run),
      .rst_pin_low(rst_pin_low), .status(status), .vec_valid(vec_valid),
      .vec_addr(vec_addr), .wdog_disable(wdog_disable)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   // m_ph: 0 running, 1 settle, 2 first window, 3 second window, 4/5 vector bytes
   int         m_ph = 0;
   int         m_cnt = 0;
   logic [3:0] m_st = 4'b0;
   bit         started = 0;

   always @(posedge clk) begin
      if (por_pulse) begin
         m_ph = 1; m_cnt = 0; m_st = 4'b0001; started = 1;
      end else if (started) begin
         bit ill, pin, hit;
         logic [3:0] bitv;
         ill  = illop_stb || (stop_stb && !stop_en);
         pin  = ext_pin_low && (m_ph == 0);
         hit  = wdog_ovf || ill || pin;
         bitv = wdog_ovf ? 4'b0010 : ill ? 4'b0100 : pin ? 4'b1000 : 4'b0000;
         if (m_ph == 0) begin
            if (hit) begin m_ph = 2; m_cnt = 0; m_st = bitv; end
         end else begin
            if (hit) m_st = m_st | bitv;
            if (hit && (m_ph == 2 || m_ph == 3)) m_cnt = 0;
            else if (hit && m_ph >= 4) begin m_ph = 3; m_cnt = 0; end
            else if (m_ph == 1) begin
               if (m_cnt == S - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
            end else if (m_ph == 2 || m_ph == 3) begin
               if (m_cnt == W - 1) begin m_ph = m_ph + 1; m_cnt = 0; end else m_cnt++;
            end else if (m_ph == 4) m_ph = 5;
            else m_ph = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (started) begin
         chk("R1", "clk_run",     clk_run,     (m_ph != 1));
         chk("R2", "rst_pin_low", rst_pin_low, (m_ph == 1 || m_ph == 2));
         chk("R2", "int_rst",     int_rst,     (m_ph >= 1 && m_ph <= 3));
         chk("R3", "vec_valid",   vec_valid,   (m_ph >= 4));
         chk("R3", "vec_addr",    vec_addr,    (m_ph == 4) ? 16'hFFFE : (m_ph == 5) ? 16'hFFFF : 16'h0);
         chk("R11", "status",     status,      m_st);
         chk("R12", "wdog_disable", wdog_disable,
             (monitor_mode && (vtst_rst || vtst_irq)) || (break_state && vtst_rst));
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic edges(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic por_run(bit inject);
      @(negedge clk); #1 por_pulse = 1'b1;
      edges(3); #1 por_pulse = 1'b0;
      edges(1);
      chk("R1", "int_rst after release", int_rst, 1);
      chk("R1", "clk_run after release", clk_run, 0);
      chk("R4", "status after power-on", status, 4'b0001);
      if (inject) begin
         edges(48); #1 wdog_ovf = 1'b1;
         edges(1);  #1 wdog_ovf = 1'b0;
         edges(S - 51);
      end else begin
         edges(S - 2);
      end
      chk("R1", "clk_run one edge before end of hold", clk_run, 0);
      edges(1);
      chk("R1", "clk_run at end of hold", clk_run, 1);
      chk("R10", "status after settle request", status, inject ? 4'b0011 : 4'b0001);
      edges(W - 1);
      chk("R2", "pin still driven", rst_pin_low, 1);
      edges(1);
      chk("R2", "pin released", rst_pin_low, 0);
      chk("R2", "int_rst in second window", int_rst, 1);
      edges(W - 1);
      chk("R2", "int_rst end of second window", int_rst, 1);
      edges(1);
      chk("R3", "int_rst released", int_rst, 0);
      chk("R3", "first vector byte", vec_addr, 16'hFFFE);
      edges(1);
      chk("R3", "second vector byte", vec_addr, 16'hFFFF);
      edges(1);
      chk("R3", "vector fetch over", vec_valid, 0);
   endtask

   // mask: 1 watchdog, 2 illegal opcode, 4 STOP, 8 pin
   task automatic req_run(int mask, logic [3:0] exp, string tag);
      @(negedge clk); #1;
      wdog_ovf = mask[0]; illop_stb = mask[1]; stop_stb = mask[2]; ext_pin_low = mask[3];
      edges(1);
      chk(tag, "int_rst on request", int_rst, 1);
      chk(tag, "status on request", status, exp);
      chk("R5", "clocks not gated", clk_run, 1);
      #1 wdog_ovf = 0; illop_stb = 0; stop_stb = 0; ext_pin_low = 0;
      edges(W - 1);
      chk(tag, "pin driven to end of first window", rst_pin_low, 1);
      edges(1);
      chk(tag, "pin released", rst_pin_low, 0);
      edges(W - 1);
      chk("R8", "own pin drive not a request, still in reset", int_rst, 1);
      edges(1);
      chk(tag, "reset released", int_rst, 0);
      chk(tag, "vector start", vec_addr, 16'hFFFE);
      edges(2);
      chk(tag, "back to running", vec_valid, 0);
      chk(tag, "status kept", status, exp);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: run not complete, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      por_run(0);
      req_run(1, 4'b0010, "R5");
      // R7: STOP while allowed does nothing
      @(negedge clk); #1 stop_en = 1'b1; stop_stb = 1'b1;
      edges(1); #1 stop_stb = 1'b0;
      edges(2);
      chk("R7", "allowed STOP no reset", int_rst, 0);
      chk("R7", "allowed STOP status", status, 4'b0010);
      #1 stop_en = 1'b0;
      req_run(4, 4'b0100, "R7");
      req_run(8, 4'b1000, "R8");
      req_run(2, 4'b0100, "R6");
      req_run(1 | 2 | 8, 4'b0010, "R9");
      req_run(2 | 8, 4'b0100, "R9");
      req_run(4 | 8, 4'b0100, "R9");
      // R11: idle running, status unchanged
      edges(40);
      chk("R11", "status after idle", status, 4'b0100);
      chk("R11", "no reset while idle", int_rst, 0);
      // R10: request inside first window and inside vector fetch
      @(negedge clk); #1 wdog_ovf = 1'b1;
      edges(1); #1 wdog_ovf = 1'b0;
      edges(9); #1 illop_stb = 1'b1;
      edges(1); #1 illop_stb = 1'b0;
      chk("R10", "status merged", status, 4'b0110);
      edges(W - 1);
      chk("R10", "first window restarted", rst_pin_low, 1);
      edges(1);
      chk("R10", "restarted window ends", rst_pin_low, 0);
      edges(W - 1);
      chk("R10", "second window running", int_rst, 1);
      edges(1);
      chk("R10", "vector fetch begins", vec_addr, 16'hFFFE);
      #1 wdog_ovf = 1'b1;
      edges(1); #1 wdog_ovf = 1'b0;
      chk("R10", "back in second window", int_rst, 1);
      chk("R10", "vector fetch aborted", vec_valid, 0);
      chk("R10", "pin stays released", rst_pin_low, 0);
      edges(W - 1);
      chk("R10", "second window again", int_rst, 1);
      edges(1);
      chk("R10", "released after re-run", int_rst, 0);
      edges(2);
      chk("R10", "status after re-run", status, 4'b0110);
      // R12: watchdog disable qualifier
      #1 monitor_mode = 1; vtst_irq = 1; #1;
      chk("R12", "monitor + irq test voltage", wdog_disable, 1);
      monitor_mode = 0; #1;
      chk("R12", "irq test voltage alone", wdog_disable, 0);
      break_state = 1; #1;
      chk("R12", "break + irq test voltage", wdog_disable, 0);
      vtst_rst = 1; vtst_irq = 0; #1;
      chk("R12", "break + reset test voltage", wdog_disable, 1);
      break_state = 0; monitor_mode = 1; #1;
      chk("R12", "monitor + reset test voltage", wdog_disable, 1);
      monitor_mode = 0; vtst_rst = 0; #1;
      chk("R12", "all low", wdog_disable, 0);
      // second power-on with a watchdog hit inside the hold
      por_run(1);
      edges(5);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule